// File: doc/BRIEF.md
# Shared-Period PWM Bank

This block generates pulse-width modulated outputs on a parameterised number of channels. All channels share a single 8-bit period counter, so every channel has the same 256-step period and starts its period on the same clock. The speed of that counter is set by an 8-bit clock divider. The divider is the only way to change the period: the counter advances once every (divider + 1) input clocks, so a period lasts 256 × (divider + 1) clocks. Each channel has its own duty register. Its output is high while the shared count is at or below the channel's duty value.

Software sets up the block through a small 32-bit register port with separate write and read strobes. There is one duty register per channel, a control word and an interrupt-enable word. Duty and divider values that are written while the block runs are held in shadow registers. They take effect only when the count wraps from 255 to 0, so a period is never cut short. Clearing the global enable stops the counter and drives every output low.

Top module: `shared_period_pwm`

## Requirements
- R1: After a synchronous active-low reset, every output is low and every register reads back 0.
- R2: Duty register k is at byte offset 4*k and keeps bits 7:0. The control word is at offset 0x50 and keeps divider bits 3:0 in bits 3:0, divider bits 7:4 in bits 14:11, and the global enable in bit 9. The interrupt-enable word is at offset 0x54 and keeps bit 0. Each register reads back the last value written, and every bit it does not keep reads as 0.
- R3: A read from an offset that maps to no register, including a duty offset at or above the channel count, returns 0. A write to such an offset changes no register.
- R4: The shared count advances once every (D+1) clocks, where D = {ctrl[14:11], ctrl[3:0]}. The count stays unchanged on the clocks in between.
- R5: A channel output is high while the count is less than or equal to that channel's duty value N. This gives (N+1)×(D+1) high clocks in each period.
- R6: A duty value of 255 keeps its output high for the whole period, and the output never goes low while running.
- R7: A new duty or divider value written while running applies only from the next wrap of the count from 255 to 0. The period in progress finishes with the old values.
- R8: While the running flag is low, the count is held at 0 and all outputs are low. The running flag follows the enable bit one clock late. The first running clock has count 0.
- R9: Read data is registered. It shows the addressed register in the clock after a read strobe and is 0 in any clock after no read strobe.
- R10: A period is always 256 counts long. The count goes up by one on each divider tick and wraps from 255 to 0, and all channels start their periods in the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW (8) | Byte offset of the register |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Registered read data |
| pwm_out | output | NUM_CH (1) | One PWM output per channel |

## Verification
The checker tests these properties on every clock: outputs stay low and the count stays parked while the block is stopped; the count changes only on a divider tick, and then by exactly one; the active divider and duty values change only at a wrap or while stopped; read data returns to 0 after a clock with no read; and a channel with full duty stays high. Some behaviour needs a known program history, so only the bench scenarios can show it. These scenarios cover the split divider field, the period length in clocks, high-time counts for several duty values, readback masking, writes to unmapped offsets that are ignored, and a duty change in mid-period that waits for the wrap. A behavioural reference model in the bench predicts every output and every read value on each clock.

// File: rtl/spwm_pkg.sv
// Package: shared constants for the shared-period PWM bank.
// Assumes byte addressing with 32-bit registers on a 4-byte stride.
package spwm_pkg;
    localparam int unsigned CTRL_OFS   = 32'h50;  // control word offset
    localparam int unsigned IEN_OFS    = 32'h54;  // interrupt-enable word offset
    localparam int unsigned NIB_W      = 4;       // width of one divider nibble
    localparam int unsigned DIV_LO_LSB = 0;       // low divider nibble position
    localparam int unsigned DIV_HI_LSB = 11;      // high divider nibble position
    localparam int unsigned RUN_BIT    = 9;       // global enable position
    localparam int unsigned MAX_CH     = CTRL_OFS / 4; // duty slots below control
endpackage

// File: rtl/spwm_regfile.sv
// Module: spwm_regfile
// Holds the programmed (shadow) duty words, control word and interrupt
// enable. Masks unused bits on write, ignores unmapped writes, and returns
// registered read data. Assumes NUM_CH <= spwm_pkg::MAX_CH.
module spwm_regfile
    import spwm_pkg::*;
#(
    parameter int unsigned NUM_CH = 1,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned AW     = 8,
    parameter int unsigned DW     = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [AW-1:0]           bus_addr,
    input  logic [DW-1:0]           bus_wdata,
    output logic [DW-1:0]           bus_rdata,
    output logic [NUM_CH*CNT_W-1:0] prog_duty_flat,
    output logic [DIV_W-1:0]        prog_div,
    output logic                    glob_en
);
    localparam int unsigned HI_W = DIV_W - NIB_W;
    localparam logic [DW-1:0] DUTY_MASK = DW'((64'd1 << CNT_W) - 64'd1);
    localparam logic [DW-1:0] CTRL_MASK =
        DW'(((64'd1 << NIB_W) - 64'd1) << DIV_LO_LSB) |
        DW'(((64'd1 << HI_W) - 64'd1) << DIV_HI_LSB) |
        DW'(64'd1 << RUN_BIT);
    localparam logic [DW-1:0] IEN_MASK  = DW'(1);

    logic [DW-1:0] duty_q [NUM_CH];
    logic [DW-1:0] ctrl_q;
    logic [DW-1:0] ien_q;
    logic [DW-1:0] rd_val;
    logic          hit_ctrl;
    logic          hit_ien;

    assign hit_ctrl = (bus_addr == AW'(CTRL_OFS));
    assign hit_ien  = (bus_addr == AW'(IEN_OFS));

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_duty
            // Per-channel duty word: load masked data on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    duty_q[g] <= '0;
                else if (bus_wr && (bus_addr == AW'(g * 4)))
                    duty_q[g] <= bus_wdata & DUTY_MASK;
            end
            assign prog_duty_flat[g*CNT_W +: CNT_W] = duty_q[g][CNT_W-1:0];
        end
    endgenerate

    // Control word: divider nibbles and global enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (bus_wr && hit_ctrl)
            ctrl_q <= bus_wdata & CTRL_MASK;
    end

    // Interrupt-enable word: stored only, no interrupt logic behind it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ien_q <= '0;
        else if (bus_wr && hit_ien)
            ien_q <= bus_wdata & IEN_MASK;
    end

    assign prog_div = {ctrl_q[DIV_HI_LSB +: HI_W], ctrl_q[DIV_LO_LSB +: NIB_W]};
    assign glob_en  = ctrl_q[RUN_BIT];

    // Read selection: unmapped offsets return zero.
    always_comb begin
        rd_val = '0;
        if (hit_ctrl)
            rd_val = ctrl_q;
        else if (hit_ien)
            rd_val = ien_q;
        else begin
            for (int k = 0; k < NUM_CH; k++) begin
                if (bus_addr == AW'(k * 4))
                    rd_val = duty_q[k];
            end
        end
    end

    // Registered read data, zero when no read is strobed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else
            bus_rdata <= bus_rd ? rd_val : '0;
    end
endmodule

// File: rtl/spwm_tick_gen.sv
// Module: spwm_tick_gen
// Clock divider that pulses tick once every (div_act + 1) clocks while run is
// high. Assumes div_act changes only at a wrap or while stopped.
module spwm_tick_gen #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_act,
    output logic             tick
);
    logic [DIV_W-1:0] div_q;

    assign tick = run && (div_q == div_act);

    // Divider count: parked at zero when stopped, restarts after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            div_q <= '0;
        else if (div_q == div_act)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/spwm_period_ctr.sv
// Module: spwm_period_ctr
// Shared period counter: advances on each tick and wraps naturally at
// 2**CNT_W. Flags the wrapping tick so that the shadow values can load.
module spwm_period_ctr #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    assign wrap = tick && (cnt == '1);

    // Period count: held at zero when stopped, steps by one per tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spwm_cmp_chan.sv
// Module: spwm_cmp_chan
// One output channel: high while running and count <= active duty.
// Assumes the count and duty come from registers, so the output has no
// glitches driven from the bus.
module spwm_cmp_chan #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] duty_act,
    output logic             pwm
);
    // Compare: a duty of all ones therefore keeps the output high.
    always_comb pwm = run && (cnt <= duty_act);
endmodule

// File: rtl/shared_period_pwm.sv
// Module: shared_period_pwm (top)
// Multi-channel PWM with one shared divider and counter. The registered
// running flag lags the enable bit by one clock, so the active values
// pick up the latest programmed values before counting starts. Active
// values reload only at a wrap while running. Assumes NUM_CH <= 20.
module shared_period_pwm
    import spwm_pkg::*;
#(
    parameter int unsigned NUM_CH = 1,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned AW     = 8,
    parameter int unsigned DW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    localparam int unsigned DUTY_BITS = NUM_CH * CNT_W;

    logic [DUTY_BITS-1:0] prog_duty_flat;
    logic [DUTY_BITS-1:0] act_duty_flat;
    logic [DIV_W-1:0]     prog_div;
    logic [DIV_W-1:0]     act_div;
    logic                 glob_en;
    logic                 run_q;
    logic                 tick;
    logic                 wrap;
    logic [CNT_W-1:0]     cnt;
    logic                 load_act;

    spwm_regfile #(
        .NUM_CH(NUM_CH), .CNT_W(CNT_W), .DIV_W(DIV_W), .AW(AW), .DW(DW)
    ) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_wr         (bus_wr),
        .bus_rd         (bus_rd),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .prog_duty_flat (prog_duty_flat),
        .prog_div       (prog_div),
        .glob_en        (glob_en)
    );

    // Running flag: follows the enable bit one clock late.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= 1'b0;
        else
            run_q <= glob_en;
    end

    assign load_act = !run_q || wrap;

    // Active values: track the programmed values while stopped, else update at wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_div       <= '0;
            act_duty_flat <= '0;
        end else if (load_act) begin
            act_div       <= prog_div;
            act_duty_flat <= prog_duty_flat;
        end
    end

    spwm_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .div_act (act_div),
        .tick    (tick)
    );

    spwm_period_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_q),
        .tick  (tick),
        .cnt   (cnt),
        .wrap  (wrap)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_chan
            spwm_cmp_chan #(.CNT_W(CNT_W)) u_cmp (
                .run      (run_q),
                .cnt      (cnt),
                .duty_act (act_duty_flat[g*CNT_W +: CNT_W]),
                .pwm      (pwm_out[g])
            );
        end
    endgenerate
endmodule

// File: rtl/shared_period_pwm_chk.sv
// Module: shared_period_pwm_chk
// Checker bound into shared_period_pwm. It watches the ports and the
// signals between the divider, counter, shadow stage and comparators.
module shared_period_pwm_chk #(
    parameter int unsigned NUM_CH = 1,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned DW     = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_rd,
    input logic [DW-1:0]           bus_rdata,
    input logic [NUM_CH-1:0]       pwm_out,
    input logic                    run_q,
    input logic                    tick,
    input logic [CNT_W-1:0]        cnt,
    input logic [DIV_W-1:0]        act_div,
    input logic [NUM_CH*CNT_W-1:0] act_duty_flat
);
    p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> (pwm_out == '0));

    p_cnt_parked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |=> (cnt == '0));

    p_tick_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && tick) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    p_hold_between_ticks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !tick) |=> $stable(cnt));

    p_div_shadow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !(tick && cnt == '1)) |=> $stable(act_div));

    p_duty_shadow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !(tick && cnt == '1)) |=> $stable(act_duty_flat));

    p_rdata_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_full
            p_full_duty_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (run_q && act_duty_flat[g*CNT_W +: CNT_W] == '1) |-> pwm_out[g]);
        end
    endgenerate
endmodule

bind shared_period_pwm shared_period_pwm_chk #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .DIV_W(DIV_W), .DW(DW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_rd        (bus_rd),
    .bus_rdata     (bus_rdata),
    .pwm_out       (pwm_out),
    .run_q         (run_q),
    .tick          (tick),
    .cnt           (cnt),
    .act_div       (act_div),
    .act_duty_flat (act_duty_flat)
);

// File: tb/tb_shared_period_pwm.sv
module tb_shared_period_pwm;
    localparam int NCH = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NCH-1:0] pwm_out;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    bit started = 0;

    always #10 clk = ~clk;  // 50 MHz

    shared_period_pwm #(.NUM_CH(NCH)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out)
    );

    // ---------------- behavioural reference model ----------------
    int m_duty [NCH];
    int m_aduty [NCH];
    int m_ctrl, m_ien, m_run, m_div, m_cnt, m_adiv, m_rdata;

    function automatic int m_pre();
        return (m_ctrl & 'hF) | (((m_ctrl >> 11) & 'hF) << 4);
    endfunction

    function automatic int m_read(int a);
        if (a == 'h50) return m_ctrl;
        if (a == 'h54) return m_ien;
        if ((a % 4) == 0 && (a / 4) < NCH) return m_duty[a / 4];
        return 0;
    endfunction

    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_ctrl = 0; m_ien = 0; m_run = 0; m_div = 0; m_cnt = 0;
            m_adiv = 0; m_rdata = 0;
            for (int k = 0; k < NCH; k++) begin m_duty[k] = 0; m_aduty[k] = 0; end
        end else begin
            m_rdata = bus_rd ? m_read(int'(bus_addr)) : 0;
            if (m_run == 0) begin
                m_div = 0; m_cnt = 0; m_adiv = m_pre();
                for (int k = 0; k < NCH; k++) m_aduty[k] = m_duty[k];
            end else if (m_div == m_adiv) begin
                m_div = 0;
                if (m_cnt == 255) begin
                    m_cnt = 0; m_adiv = m_pre();
                    for (int k = 0; k < NCH; k++) m_aduty[k] = m_duty[k];
                end else m_cnt = m_cnt + 1;
            end else m_div = m_div + 1;
            m_run = (m_ctrl >> 9) & 1;
            if (bus_wr) begin
                if (bus_addr == 8'h50) m_ctrl = int'(bus_wdata & 32'h7A0F);
                else if (bus_addr == 8'h54) m_ien = int'(bus_wdata & 32'h1);
                else if (bus_addr[1:0] == 2'b00 && int'(bus_addr) / 4 < NCH)
                    m_duty[int'(bus_addr) / 4] = int'(bus_wdata & 32'hFF);
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Per-clock comparison against the model (R5 outputs, R9 read data).
    always @(negedge clk) begin
        if (started && !finished) begin
            logic [NCH-1:0] exp_out;
            for (int k = 0; k < NCH; k++)
                exp_out[k] = (m_run != 0) && (m_cnt <= m_aduty[k]);
            chk("R5", "model pwm_out", 32'(pwm_out), 32'(exp_out));
            chk("R9", "model bus_rdata", bus_rdata, m_rdata);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(req, $sformatf("read 0x%0h", a), bus_rdata, exp);
    endtask

    task automatic wait_rise0();
        logic prev;
        prev = pwm_out[0];
        forever begin
            @(negedge clk);
            if (!prev && pwm_out[0]) break;
            prev = pwm_out[0];
        end
    endtask

    // ---------------- scenarios ----------------
    initial begin
        int h0, h1, h2, n;
        logic all_hi;
        repeat (4) @(negedge clk);
        chk("R1", "pwm_out in reset", 32'(pwm_out), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "pwm_out after reset", 32'(pwm_out), 32'h0);
        rd_chk("R1", 8'h00, 32'h0);
        rd_chk("R1", 8'h50, 32'h0);
        rd_chk("R1", 8'h54, 32'h0);

        // R2 masking and readback
        wr(8'h00, 32'hFFFF_FF40);
        rd_chk("R2", 8'h00, 32'h40);
        wr(8'h50, 32'hFFFF_FDFF);
        rd_chk("R2", 8'h50, 32'h780F);
        wr(8'h54, 32'hFFFF_FFFF);
        rd_chk("R2", 8'h54, 32'h1);

        // R3 unmapped offsets
        wr(8'h0C, 32'h55);
        rd_chk("R3", 8'h0C, 32'h0);
        wr(8'h58, 32'h77);
        rd_chk("R3", 8'h58, 32'h0);
        wr(8'h40, 32'h12);
        rd_chk("R3", 8'h40, 32'h0);
        rd_chk("R3", 8'h00, 32'h40);
        rd_chk("R3", 8'h50, 32'h780F);

        // R8 enable timing, R5/R6/R10 at divider 0
        wr(8'h50, 32'h0);
        wr(8'h00, 32'd9);
        wr(8'h04, 32'd0);
        wr(8'h08, 32'd255);
        wr(8'h50, 32'h200);
        chk("R8", "outputs low before running", 32'(pwm_out), 32'h0);
        @(negedge clk);
        chk("R8", "first running clock all high", 32'(pwm_out), 32'h7);
        wait_rise0();
        chk("R10", "channels share period start", 32'(pwm_out), 32'h7);
        h0 = 1; h1 = 1; h2 = 1;
        repeat (255) begin
            @(negedge clk);
            h0 += pwm_out[0]; h1 += pwm_out[1]; h2 += pwm_out[2];
        end
        chk("R5", "high clocks duty 9 div 0", h0, 10);
        chk("R5", "high clocks duty 0 div 0", h1, 1);
        chk("R6", "high clocks duty 255 div 0", h2, 256);

        // R4 split divider 0x21 -> period 256*34
        wr(8'h50, 32'h0);
        wr(8'h50, 32'h0000_1201);
        wait_rise0();
        n = 0; h0 = 1; all_hi = 1'b1;
        forever begin
            @(negedge clk);
            n++;
            if (pwm_out[2] !== 1'b1) all_hi = 1'b0;
            if (pwm_out[0] && n > 1 && h0 == 340 && n == 256 * 34) break;
            if (pwm_out[0]) h0++;
            if (n > 256 * 40) break;
        end
        chk("R4", "period clocks divider 0x21", n, 256 * 34);
        chk("R5", "high clocks duty 9 div 0x21", h0, 340);
        chk("R6", "duty 255 never low", 32'(all_hi), 32'h1);

        // R7 shadowing: divider 1, mid-period duty change
        wr(8'h50, 32'h0000_0201);
        wait_rise0();
        wait_rise0();
        repeat (40) @(negedge clk);
        wr(8'h00, 32'd200);
        all_hi = 1'b0;
        repeat (20) begin
            @(negedge clk);
            if (pwm_out[0]) all_hi = 1'b1;
        end
        chk("R7", "old duty holds until wrap", 32'(all_hi), 32'h0);
        wait_rise0();
        h0 = 1;
        repeat (511) begin
            @(negedge clk);
            h0 += pwm_out[0];
        end
        chk("R7", "new duty after wrap", h0, 402);

        // R8 disable
        wr(8'h50, 32'h0);
        @(negedge clk);
        chk("R8", "outputs low after disable", 32'(pwm_out), 32'h0);
        all_hi = 1'b0;
        repeat (300) begin
            @(negedge clk);
            if (pwm_out != '0) all_hi = 1'b1;
        end
        chk("R8", "outputs stay low while stopped", 32'(all_hi), 32'h0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule